// File: doc/BRIEF.md
# Prescaled Compare Timer

This block is an up-counting timer on a small word-addressed register bus. A prescale counter runs on every enabled clock. When it reaches the programmed divisor it returns to zero and advances the main count by one. A single compare channel watches the value the count is about to take. When that value equals the programmed compare value, three independent actions can follow. Each has its own control bit: latch an interrupt flag, clear the count, and stop the timer by dropping its enable bit.

There are two typical uses. For a free-running time base, software clears the match actions, sets the divisor and enables the count. For a one-shot event, software sets the compare value to 1 and turns on all three actions. It then loads a delay D into the divisor and enables the timer. Exactly D+1 clocks later the interrupt rises, the count reads zero and the timer has halted itself. Only plain timer mode exists, so the count-mode register always reads back zero.

The bus has no handshake. A write takes effect on the clock edge where `bus_we` is high, and `bus_rdata` is a combinational function of `bus_addr`. The interrupt is a level that stays high until software clears the flag.

Top module: `tmt_top`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: The control register sits at byte offset 0x004. Bit 0 enables counting and bit 1 holds both the count and the prescale counter at zero while it is 1. With bit 0 clear and bit 1 clear, the count keeps its value.
- R3: The divisor register sits at 0x008+4 = 0x00C. With divisor P, the count at 0x008 advances once every P+1 enabled clocks, so it reads N/(P+1) (integer division) N clocks after enabling from a cleared state.
- R4: The count is 32 bits wide and wraps from 0xFFFFFFFF to 0 when clear-on-match is off.
- R5: The compare value sits at 0x018. A match occurs when the count is about to advance to that value, and it sets the flag in bit 0 of the status register at 0x000 on that edge. `irq` is that flag ANDed with bit 0 of the match-action register at 0x014.
- R6: When bit 1 of the match-action register is set, a match loads the count with zero instead of the compare value.
- R7: When bit 2 of the match-action register is set, a match clears control bit 0, and the count then stays put.
- R8: Writing 1 to status bit 0 clears the flag, and writing 0 leaves it unchanged. A match on the same edge as a clearing write leaves the flag set.
- R9: With compare value 1, match actions 0b111 and divisor D, enabling the timer from a cleared state raises `irq` exactly D+1 clocks later. The count then reads 0 and the control register reads 0.
- R10: Writes to the count and the divisor load the written value directly. A bus write to the count or the control register on the same edge as a tick or a stop takes precedence over the hardware update.
- R11: The count-mode register at 0x070 and every unmapped offset read zero, and writes to them change no other register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (8) | Byte offset of the register accessed |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Level interrupt: match flag AND interrupt enable |

## Verification
Two actions can land on the same edge. One is a hardware match that sets the flag; the other is a software write of 1 to the status register that clears it. The bench runs the counter with divisor 0 and aims the clearing write at the exact edge where the count reaches the compare value. The flag must read 1 afterwards, and `irq` must stay high. The bench also aims a control write at the edge where stop-on-match fires. It then checks that the enable bit survives and that the count keeps advancing on the next clock.

// File: rtl/tmt_pkg.sv
package tmt_pkg;

  localparam int DATA_W = 32;

  // Byte offsets of the registers (software-visible map)
  localparam int OFF_STAT = 'h000;
  localparam int OFF_CTL  = 'h004;
  localparam int OFF_CNT  = 'h008;
  localparam int OFF_DIV  = 'h00C;
  localparam int OFF_ACT  = 'h014;
  localparam int OFF_CMP  = 'h018;
  localparam int OFF_MODE = 'h070;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_STAT,
    SEL_CTL,
    SEL_CNT,
    SEL_DIV,
    SEL_ACT,
    SEL_CMP,
    SEL_MODE
  } reg_sel_e;

  // Match actions, bit 0 = interrupt enable
  typedef struct packed {
    logic halt;
    logic zero;
    logic ie;
  } match_act_t;

endpackage

// File: rtl/tmt_decode.sv
module tmt_decode #(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output tmt_pkg::reg_sel_e sel
);
  import tmt_pkg::*;

  always_comb begin
    if      (addr == ADDR_W'(OFF_STAT)) sel = SEL_STAT;
    else if (addr == ADDR_W'(OFF_CTL))  sel = SEL_CTL;
    else if (addr == ADDR_W'(OFF_CNT))  sel = SEL_CNT;
    else if (addr == ADDR_W'(OFF_DIV))  sel = SEL_DIV;
    else if (addr == ADDR_W'(OFF_ACT))  sel = SEL_ACT;
    else if (addr == ADDR_W'(OFF_CMP))  sel = SEL_CMP;
    else if (addr == ADDR_W'(OFF_MODE)) sel = SEL_MODE;
    else                                sel = SEL_NONE;
  end

endmodule

// File: rtl/tmt_count.sv
module tmt_count #(
  parameter int CNT_W = 32,
  parameter int PRE_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             hold,
  input  logic [PRE_W-1:0] div,
  input  logic [CNT_W-1:0] cmp,
  input  logic             zero_on_hit,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count,
  output logic             hit
);

  logic [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] count_inc;
  logic             tick;

  assign tick      = run && !hold && (pre_q == div);
  assign count_inc = count_q + CNT_W'(1);
  // A bus load of the count wins; no match is judged on that edge
  assign hit       = tick && !load && (count_inc == cmp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         pre_q <= '0;
    else if (hold)      pre_q <= '0;
    else if (run) begin
      if (pre_q == div) pre_q <= '0;
      else              pre_q <= pre_q + PRE_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count_q <= '0;
    else if (hold) count_q <= '0;
    else if (load) count_q <= load_val;
    else if (tick) count_q <= (hit && zero_on_hit) ? '0 : count_inc;
  end

  assign count = count_q;

endmodule

// File: rtl/tmt_regs.sv
module tmt_regs #(
  parameter int CNT_W = 32,
  parameter int PRE_W = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       we,
  input  tmt_pkg::reg_sel_e          sel,
  input  logic [tmt_pkg::DATA_W-1:0] wdata,
  input  logic                       hit,
  input  logic [CNT_W-1:0]           count,
  output logic                       run,
  output logic                       hold,
  output logic [PRE_W-1:0]           div,
  output tmt_pkg::match_act_t        act,
  output logic [CNT_W-1:0]           cmp,
  output logic                       flag,
  output logic [tmt_pkg::DATA_W-1:0] rdata
);
  import tmt_pkg::*;

  logic ctl_wr, stat_wr;
  assign ctl_wr  = we && (sel == SEL_CTL);
  assign stat_wr = we && (sel == SEL_STAT);

  // Control: bus write wins over stop-on-match
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run  <= 1'b0;
      hold <= 1'b0;
    end else if (ctl_wr) begin
      run  <= wdata[0];
      hold <= wdata[1];
    end else if (hit && act.halt) begin
      run  <= 1'b0;
    end
  end

  // Match flag: a set beats a clearing write on the same edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    flag <= 1'b0;
    else if (hit)                  flag <= 1'b1;
    else if (stat_wr && wdata[0])  flag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div <= '0;
      act <= '0;
      cmp <= '0;
    end else if (we) begin
      if (sel == SEL_DIV) div <= wdata[PRE_W-1:0];
      if (sel == SEL_ACT) act <= match_act_t'(wdata[2:0]);
      if (sel == SEL_CMP) cmp <= wdata[CNT_W-1:0];
    end
  end

  always_comb begin
    case (sel)
      SEL_STAT: rdata = DATA_W'(flag);
      SEL_CTL:  rdata = DATA_W'({hold, run});
      SEL_CNT:  rdata = DATA_W'(count);
      SEL_DIV:  rdata = DATA_W'(div);
      SEL_ACT:  rdata = DATA_W'(act);
      SEL_CMP:  rdata = DATA_W'(cmp);
      default:  rdata = '0;  // mode register and unmapped space
    endcase
  end

endmodule

// File: rtl/tmt_top.sv
module tmt_top #(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 32,
  parameter int PRE_W  = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic                       bus_we,
  input  logic [tmt_pkg::DATA_W-1:0] bus_wdata,
  output logic [tmt_pkg::DATA_W-1:0] bus_rdata,
  output logic                       irq
);
  import tmt_pkg::*;

  reg_sel_e         sel;
  logic             run, hold, flag, hit, cnt_load;
  logic [PRE_W-1:0] div;
  logic [CNT_W-1:0] cmp, count;
  match_act_t       act;

  tmt_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (bus_addr),
    .sel  (sel)
  );

  assign cnt_load = bus_we && (sel == SEL_CNT);

  tmt_regs #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (bus_we),
    .sel   (sel),
    .wdata (bus_wdata),
    .hit   (hit),
    .count (count),
    .run   (run),
    .hold  (hold),
    .div   (div),
    .act   (act),
    .cmp   (cmp),
    .flag  (flag),
    .rdata (bus_rdata)
  );

  tmt_count #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_cnt (
    .clk         (clk),
    .rst_n       (rst_n),
    .run         (run),
    .hold        (hold),
    .div         (div),
    .cmp         (cmp),
    .zero_on_hit (act.zero),
    .load        (cnt_load),
    .load_val    (bus_wdata[CNT_W-1:0]),
    .count       (count),
    .hit         (hit)
  );

  assign irq = flag && act.ie;

endmodule

// File: rtl/tmt_checker.sv
module tmt_checker #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             hold,
  input logic             hit,
  input logic             flag,
  input logic [2:0]       act_bits,
  input logic [CNT_W-1:0] count,
  input logic             bus_we,
  input logic [2:0]       sel_bits,
  input logic             wbit0
);
  import tmt_pkg::*;

  logic cnt_wr, ctl_wr, stat_wr;
  assign cnt_wr  = bus_we && (sel_bits == 3'(SEL_CNT));
  assign ctl_wr  = bus_we && (sel_bits == 3'(SEL_CTL));
  assign stat_wr = bus_we && (sel_bits == 3'(SEL_STAT));

  a_r2_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (count == '0));

  a_r2_idle_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !hold && !cnt_wr) |=> $stable(count));

  a_r3_step_one: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && !cnt_wr && !hit) |=>
      ((count == $past(count)) || (count == CNT_W'($past(count) + CNT_W'(1)))));

  a_r5_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> flag);

  a_r6_zero_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && act_bits[1]) |=> (count == '0));

  a_r7_halt_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && act_bits[2] && !ctl_wr) |=> !run);

  a_r8_clear_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && wbit0 && !hit) |=> !flag);

endmodule

bind tmt_top tmt_checker #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .run      (run),
  .hold     (hold),
  .hit      (hit),
  .flag     (flag),
  .act_bits (act),
  .count    (count),
  .bus_we   (bus_we),
  .sel_bits (sel),
  .wbit0    (bus_wdata[0])
);

// File: tb/tmt_top_tb.sv
`timescale 1ns/1ps
module tmt_top_tb;

  localparam logic [7:0] A_STAT = 8'h00, A_CTL = 8'h04, A_CNT = 8'h08,
                         A_DIV = 8'h0C, A_ACT = 8'h14, A_CMP = 8'h18,
                         A_MODE = 8'h70;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int vectors = 0;
  int misses = 0;
  bit done = 0;

  always #2 clk = ~clk;  // 250 MHz

  tmt_top u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  function automatic int exp_count(int n, int p);
    return n / (p + 1);
  endfunction

  function automatic int exp_delay(int d);
    return d + 1;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called at a negedge; the write lands on the next rising edge
  task automatic wr(logic [7:0] a, logic [31:0] d);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      vectors++; misses++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int seed;
    seed = $urandom(32'h5EED_0042);
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values
    rd(A_STAT, v); check("R1 stat", v, 0);
    rd(A_CTL, v);  check("R1 ctl", v, 0);
    rd(A_CNT, v);  check("R1 cnt", v, 0);
    rd(A_DIV, v);  check("R1 div", v, 0);
    rd(A_ACT, v);  check("R1 act", v, 0);
    rd(A_CMP, v);  check("R1 cmp", v, 0);
    check("R1 irq", 32'(irq), 0);

    // R2 hold while reset bit set, even with enable
    wr(A_CNT, 32'd77);
    wr(A_CTL, 32'd3);
    idle(5);
    rd(A_CNT, v); check("R2 held", v, 0);
    // R2/R10 disabled count keeps a loaded value
    wr(A_CTL, 32'd0);
    wr(A_CNT, 32'd100);
    idle(6);
    rd(A_CNT, v); check("R2 idle keep", v, 100);
    wr(A_DIV, 32'hDEAD_BEEF);
    rd(A_DIV, v); check("R10 div load", v, 32'hDEAD_BEEF);

    // R3 prescaler, random divisors and waits
    for (int it = 0; it < 8; it++) begin
      int p, n;
      p = (it == 0) ? 0 : int'($urandom % 6);
      n = 1 + int'($urandom % 40);
      wr(A_ACT, 32'd0);
      wr(A_CMP, 32'd0);
      wr(A_DIV, 32'(p));
      wr(A_CTL, 32'd2);
      wr(A_CTL, 32'd1);
      idle(n);
      rd(A_CNT, v); check("R3 prescale", v, 32'(exp_count(n, p)));
    end

    // R4 wrap
    wr(A_CTL, 32'd0);
    wr(A_DIV, 32'd0);
    wr(A_CMP, 32'd5);
    wr(A_CNT, 32'hFFFF_FFFE);
    wr(A_CTL, 32'd1);
    idle(1);
    rd(A_CNT, v); check("R4 pre-wrap", v, 32'hFFFF_FFFF);
    idle(1);
    rd(A_CNT, v); check("R4 wrap", v, 0);

    // R10 count load beats a tick
    wr(A_CNT, 32'd50);
    rd(A_CNT, v); check("R10 cnt load", v, 50);
    idle(1);
    rd(A_CNT, v); check("R10 after load", v, 51);

    // R5 flag without enable, then mask on
    wr(A_CTL, 32'd0);
    wr(A_STAT, 32'd1);
    wr(A_CMP, 32'd3);
    wr(A_CTL, 32'd2);
    wr(A_CTL, 32'd1);
    idle(2);
    rd(A_STAT, v); check("R5 no early flag", v, 0);
    idle(1);
    rd(A_STAT, v); check("R5 flag set", v, 1);
    check("R5 irq masked", 32'(irq), 0);
    wr(A_ACT, 32'd1);
    check("R5 irq unmasked", 32'(irq), 1);

    // R8 write 0 no effect, write 1 clears
    wr(A_STAT, 32'd0);
    rd(A_STAT, v); check("R8 zero write", v, 1);
    wr(A_STAT, 32'd1);
    rd(A_STAT, v); check("R8 clear", v, 0);
    check("R8 irq low", 32'(irq), 0);

    // R8 set beats clear on the same edge
    wr(A_CTL, 32'd2);
    wr(A_CTL, 32'd1);
    idle(2);
    wr(A_STAT, 32'd1);   // lands on the matching edge
    rd(A_STAT, v); check("R8 set wins", v, 1);
    check("R8 irq kept", 32'(irq), 1);

    // R6 clear on match
    wr(A_CTL, 32'd0);
    wr(A_STAT, 32'd1);
    wr(A_ACT, 32'd2);
    wr(A_CMP, 32'd4);
    wr(A_CTL, 32'd2);
    wr(A_CTL, 32'd1);
    idle(4);
    rd(A_CNT, v); check("R6 zeroed", v, 0);
    rd(A_STAT, v); check("R6 flag", v, 1);
    idle(1);
    rd(A_CNT, v); check("R6 restart", v, 1);

    // R7 stop without clear
    wr(A_CTL, 32'd0);
    wr(A_ACT, 32'd4);
    wr(A_CMP, 32'd3);
    wr(A_CTL, 32'd2);
    wr(A_CTL, 32'd1);
    idle(3);
    rd(A_CTL, v); check("R7 halted", v, 0);
    idle(4);
    rd(A_CNT, v); check("R7 count kept", v, 3);

    // R10 control write beats the stop
    wr(A_CTL, 32'd2);
    wr(A_CTL, 32'd1);
    idle(2);
    wr(A_CTL, 32'd1);    // lands on the matching edge
    rd(A_CTL, v); check("R10 ctl wins", v, 1);
    idle(1);
    rd(A_CNT, v); check("R10 keeps counting", v, 4);

    // R9 one-shot, random delays plus corners
    for (int it = 0; it < 10; it++) begin
      int d;
      bit early;
      d = (it == 0) ? 0 : (it == 1) ? 1 : int'($urandom % 25);
      wr(A_CTL, 32'd0);
      wr(A_STAT, 32'd1);
      wr(A_CMP, 32'd1);
      wr(A_ACT, 32'd7);
      wr(A_DIV, 32'(d));
      wr(A_CTL, 32'd2);
      wr(A_CTL, 32'd1);
      early = irq;
      for (int k = 1; k < exp_delay(d); k++) begin
        @(negedge clk);
        if (irq) early = 1;
      end
      check("R9 no early irq", 32'(early), 0);
      @(negedge clk);
      check("R9 irq at D+1", 32'(irq), 1);
      rd(A_CNT, v); check("R9 count zero", v, 0);
      rd(A_CTL, v); check("R9 ctl zero", v, 0);
      idle(3);
      rd(A_CNT, v); check("R9 stays stopped", v, 0);
    end

    // R11 mode register and unmapped offsets
    wr(A_CTL, 32'd0);
    wr(A_STAT, 32'd1);
    wr(A_DIV, 32'd7);
    wr(A_CMP, 32'd9);
    wr(A_ACT, 32'd0);
    wr(A_CNT, 32'd33);
    wr(A_MODE, 32'hFFFF_FFFF);
    wr(8'h10, 32'hFFFF_FFFF);
    wr(8'h1C, 32'hFFFF_FFFF);
    wr(8'hFC, 32'hFFFF_FFFF);
    rd(A_MODE, v); check("R11 mode zero", v, 0);
    rd(8'h10, v);  check("R11 unmapped 10", v, 0);
    rd(8'hFC, v);  check("R11 unmapped FC", v, 0);
    rd(A_DIV, v);  check("R11 div intact", v, 7);
    rd(A_CMP, v);  check("R11 cmp intact", v, 9);
    rd(A_ACT, v);  check("R11 act intact", v, 0);
    rd(A_CTL, v);  check("R11 ctl intact", v, 0);
    rd(A_CNT, v);  check("R11 cnt intact", v, 33);
    rd(A_STAT, v); check("R11 stat intact", v, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule